// File: doc/BRIEF.md
# Channel status rewriter

This block sits inline on a decoded two-channel digital audio stream, one subframe per valid cycle. Each subframe word holds four preamble positions (bits 3..0, unused here), 24 audio and auxiliary bits (bits 27..4), the validity bit (28), the user bit (29), the channel-status bit (30) and the parity bit (31). A channel flag tells channel 1 (`0`) from channel 2 (`1`). A block-start flag marks the channel-1 subframe that carries status bit 0 of a new block. Channel-status bits are numbered by counting channel-1 subframes from the block start, so the bit at index k comes from the k-th channel-1 subframe of the block.

The block follows the block position of the channel-1 stream and collects the source status bits. At the end of every complete, uninterrupted block it decodes the consumer-format fields and reports them. When rewriting is enabled, it changes the status bits at indices 0, 2 and 3, so that material marked professional, copy-prohibited or emphasised is accepted by a consumer input. Wherever a status bit is changed, the parity bit is recomputed. The stream is delayed by exactly one register stage.

Top module: `csrw_rewriter`

## Requirements
- R1: Every input cycle appears at the output exactly one clock later, with `out_valid`, `out_chan` and `out_bos` equal to the input values of that earlier cycle.
- R2: Channel-2 subframes (`in_chan`=1) leave the block bit-for-bit unchanged.
- R3: With `rw_en`=0, every subframe leaves the block bit-for-bit unchanged.
- R4: With `rw_en`=1, inside a tracked block, the channel-1 status bit (bit 30) is forced to 0 at index 0, to 1 at index 2 and to 0 at index 3. All other indices, including index 1, and all other bit positions pass through unchanged.
- R5: When R4 changes bit 30, bit 31 is rewritten so that bits 31..4 have even parity. When bit 30 already holds the forced value, bit 31 is passed through untouched, even if the incoming parity is wrong.
- R6: A channel-1 subframe with `in_bos`=1 is index 0, and the channel-1 subframes after it take the following indices. After reset, no index is tracked and nothing is rewritten until the first block start.
- R7: On the clock after the channel-1 subframe at index `BLOCK_LEN`-1 of an uninterrupted block, `st_valid` is 1 and the status outputs show that block's source bits (before any rewrite): `st_pro`=C0, `st_nonaudio`=C1, `st_copy_ok`=C2, `st_emph`={C4,C3}, `st_mode`={C7,C6}.
- R8: When `st_mode`=00, `st_category[i]`=C(8+i) and `st_rate`={C25,C24} (00 means 44.1 kHz, 10 means 48 kHz, 11 means 32 kHz). For any other mode, both are reported as zero.
- R9: `st_is_dat` is 1 when the mode is 0 and `st_category`=8'h03 (C8=C9=1). `st_is_datp` is 1 when the mode is 0 and `st_category`=8'h83 (C8, C9 and C15 set).
- R10: A block start that arrives before `BLOCK_LEN` channel-1 subframes have passed clears `st_valid` on the next clock, and a new block starts. A channel-1 subframe without a block start after `BLOCK_LEN` subframes also clears `st_valid`, and it stops tracking (and so rewriting) until the next block start.
- R11: During and right after reset, `out_valid`, `st_valid` and all status outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rw_en | input | 1 | Enable the status-bit rewrite |
| in_valid | input | 1 | Input subframe present |
| in_chan | input | 1 | Input channel, 0 for channel 1 and 1 for channel 2 |
| in_bos | input | 1 | Input subframe starts a block |
| in_sub | input | 32 | Input subframe word |
| out_valid | output | 1 | Output subframe present |
| out_chan | output | 1 | Output channel |
| out_bos | output | 1 | Output block-start flag |
| out_sub | output | 32 | Output subframe word |
| st_valid | output | 1 | Status fields come from a complete block |
| st_pro | output | 1 | Professional-format flag (C0) |
| st_nonaudio | output | 1 | Non-audio flag (C1) |
| st_copy_ok | output | 1 | Copy-permitted flag (C2) |
| st_emph | output | 2 | Emphasis code {C4,C3} |
| st_mode | output | 2 | Mode {C7,C6} |
| st_category | output | 8 | Category code, bit i = C(8+i), mode 0 only |
| st_rate | output | 2 | Rate code {C25,C24}, mode 0 only |
| st_is_dat | output | 1 | Category is tape (8'h03) |
| st_is_datp | output | 1 | Category is tape, copy permitted (8'h83) |

## Verification
The assertions assume that the block-start flag is raised only on channel-1 subframes, and that the inputs stay at zero while reset is applied. They also assume that no input carries an unknown value once reset has been released. The bench drives the inputs on the falling edge. It raises the block-start flag only on channel-1 subframes, and it inserts idle cycles only between frames. Its own model of the block position follows the index rules of R6 and R10, and it gives the expected stream and the expected status fields for every subframe.

// File: rtl/csrw_pkg.sv
package csrw_pkg;

   localparam int SUB_W  = 32;
   localparam int C_POS  = 30;
   localparam int P_POS  = 31;
   localparam int PAR_LO = 4;

   typedef struct packed {
      logic       pro;
      logic       nonaudio;
      logic       copy_ok;
      logic [1:0] emph;
      logic [1:0] mode;
      logic [7:0] category;
      logic [1:0] rate;
      logic       is_dat;
      logic       is_datp;
   } cs_status_t;

endpackage

// File: rtl/csrw_block_tracker.sv
module csrw_block_tracker #(
   parameter int BLOCK_LEN = 192,
   parameter int IDX_W     = $clog2(BLOCK_LEN + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sub_valid,
   input  logic             sub_chan,
   input  logic             sub_bos,
   output logic             cur_sync,
   output logic [IDX_W-1:0] cur_idx,
   output logic             blk_last,
   output logic             blk_err
);

   localparam logic [IDX_W-1:0] FULL = IDX_W'(BLOCK_LEN);
   localparam logic [IDX_W-1:0] LAST = IDX_W'(BLOCK_LEN - 1);

   logic [IDX_W-1:0] cnt_q;
   logic             sync_q;
   logic             c1;

   assign c1 = sub_valid && !sub_chan;

   always_comb begin
      cur_sync = c1 && (sub_bos || (sync_q && cnt_q != FULL));
      cur_idx  = sub_bos ? '0 : cnt_q;
      blk_last = cur_sync && (cur_idx == LAST);
      blk_err  = c1 && sync_q && (sub_bos ? (cnt_q != FULL) : (cnt_q == FULL));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         sync_q <= 1'b0;
      end else if (c1) begin
         if (sub_bos) begin
            cnt_q  <= IDX_W'(1);
            sync_q <= 1'b1;
         end else if (sync_q) begin
            if (cnt_q == FULL) sync_q <= 1'b0;
            else               cnt_q  <= cnt_q + IDX_W'(1);
         end
      end
   end

   assert_cnt_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= FULL);

   assert_bos_starts_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (c1 && sub_bos) |=> (sync_q && cnt_q == IDX_W'(1)));

   assert_late_drops_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (c1 && !sub_bos && sync_q && cnt_q == FULL) |=> !sync_q);

endmodule

// File: rtl/csrw_status_decode.sv
module csrw_status_decode
   import csrw_pkg::*;
#(
   parameter int         CAP_BITS = 26,
   parameter int         IDX_W    = 8,
   parameter logic [7:0] CAT_DAT  = 8'h03,
   parameter logic [7:0] CAT_DATP = 8'h83
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cur_sync,
   input  logic [IDX_W-1:0] cur_idx,
   input  logic             c_bit,
   input  logic             blk_last,
   input  logic             blk_err,
   output cs_status_t       st,
   output logic             st_valid
);

   initial begin
      assert (CAP_BITS >= 26) else $error("CAP_BITS must cover status bit 25");
   end

   logic [CAP_BITS-1:0] cap_q;
   cs_status_t          dec;
   logic                mode0;
   logic                unused_cap;

   for (genvar i = 0; i < CAP_BITS; i++) begin : g_cap
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                    cap_q[i] <= 1'b0;
         else if (cur_sync && cur_idx == IDX_W'(i))     cap_q[i] <= c_bit;
      end
   end

   assign unused_cap = ^cap_q;

   always_comb begin
      mode0        = (cap_q[7:6] == 2'b00);
      dec.pro      = cap_q[0];
      dec.nonaudio = cap_q[1];
      dec.copy_ok  = cap_q[2];
      dec.emph     = {cap_q[4], cap_q[3]};
      dec.mode     = {cap_q[7], cap_q[6]};
      dec.category = mode0 ? cap_q[15:8] : 8'h00;
      dec.rate     = mode0 ? {cap_q[25], cap_q[24]} : 2'b00;
      dec.is_dat   = mode0 && (cap_q[15:8] == CAT_DAT);
      dec.is_datp  = mode0 && (cap_q[15:8] == CAT_DATP);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= '0;
         st_valid <= 1'b0;
      end else begin
         if (blk_last) st <= dec;
         if (blk_err)       st_valid <= 1'b0;
         else if (blk_last) st_valid <= 1'b1;
      end
   end

   assert_valid_after_block_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(st_valid) |-> $past(blk_last));

   assert_valid_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(st_valid) |-> $past(blk_err));

   assert_mode_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (st.mode != 2'b00) |-> (st.category == 8'h00 && st.rate == 2'b00));

   assert_flags_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({st.is_dat, st.is_datp}));

endmodule

// File: rtl/csrw_bit_rewrite.sv
module csrw_bit_rewrite
   import csrw_pkg::*;
#(
   parameter int IDX_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rw_en,
   input  logic             sub_valid,
   input  logic             sub_chan,
   input  logic             sub_bos,
   input  logic [SUB_W-1:0] sub_data,
   input  logic             cur_sync,
   input  logic [IDX_W-1:0] cur_idx,
   output logic             out_valid,
   output logic             out_chan,
   output logic             out_bos,
   output logic [SUB_W-1:0] out_data
);

   localparam int              NFORCE = 3;
   localparam int              FORCE_IDX [NFORCE] = '{0, 2, 3};
   localparam logic [NFORCE-1:0] FORCE_VAL = 3'b010;

   logic [NFORCE-1:0] hit;
   logic              do_force;
   logic              forced_c;
   logic [SUB_W-1:0]  nxt;

   for (genvar k = 0; k < NFORCE; k++) begin : g_hit
      assign hit[k] = (cur_idx == IDX_W'(FORCE_IDX[k]));
   end

   always_comb begin
      do_force = rw_en && cur_sync && (|hit);
      forced_c = |(hit & FORCE_VAL);
      nxt      = sub_data;
      if (do_force && sub_data[C_POS] != forced_c) begin
         nxt[C_POS] = forced_c;
         nxt[P_POS] = ^nxt[P_POS-1:PAR_LO];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_chan  <= 1'b0;
         out_bos   <= 1'b0;
         out_data  <= '0;
      end else begin
         out_valid <= sub_valid;
         out_chan  <= sub_chan;
         out_bos   <= sub_bos;
         out_data  <= nxt;
      end
   end

   assert_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (out_valid == $past(sub_valid) && out_chan == $past(sub_chan)
                && out_bos == $past(sub_bos)));

   assert_ch2_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (sub_valid && sub_chan) |=> (out_data == $past(sub_data)));

   assert_off_pass_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !rw_en |=> (out_data == $past(sub_data)));

   assert_even_parity_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (rw_en && cur_sync) |=> ((out_data[C_POS] == $past(sub_data[C_POS]))
                               || (^out_data[P_POS:PAR_LO] == 1'b0)));

endmodule

// File: rtl/csrw_rewriter.sv
module csrw_rewriter
   import csrw_pkg::*;
#(
   parameter int         BLOCK_LEN = 192,
   parameter int         CAP_BITS  = 26,
   parameter logic [7:0] CAT_DAT   = 8'h03,
   parameter logic [7:0] CAT_DATP  = 8'h83
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       rw_en,
   input  logic       in_valid,
   input  logic       in_chan,
   input  logic       in_bos,
   input  logic [31:0] in_sub,
   output logic       out_valid,
   output logic       out_chan,
   output logic       out_bos,
   output logic [31:0] out_sub,
   output logic       st_valid,
   output logic       st_pro,
   output logic       st_nonaudio,
   output logic       st_copy_ok,
   output logic [1:0] st_emph,
   output logic [1:0] st_mode,
   output logic [7:0] st_category,
   output logic [1:0] st_rate,
   output logic       st_is_dat,
   output logic       st_is_datp
);

   localparam int IDX_W = $clog2(BLOCK_LEN + 1);

   initial begin
      assert (BLOCK_LEN > CAP_BITS) else $error("BLOCK_LEN must exceed CAP_BITS");
      assert (SUB_W == 32) else $error("subframe width must be 32");
   end

   logic             cur_sync;
   logic [IDX_W-1:0] cur_idx;
   logic             blk_last;
   logic             blk_err;
   cs_status_t       st;

   csrw_block_tracker #(.BLOCK_LEN(BLOCK_LEN), .IDX_W(IDX_W)) trk_i (
      .clk(clk), .rst_n(rst_n), .sub_valid(in_valid), .sub_chan(in_chan),
      .sub_bos(in_bos), .cur_sync(cur_sync), .cur_idx(cur_idx),
      .blk_last(blk_last), .blk_err(blk_err)
   );

   csrw_status_decode #(.CAP_BITS(CAP_BITS), .IDX_W(IDX_W),
                        .CAT_DAT(CAT_DAT), .CAT_DATP(CAT_DATP)) dec_i (
      .clk(clk), .rst_n(rst_n), .cur_sync(cur_sync), .cur_idx(cur_idx),
      .c_bit(in_sub[C_POS]), .blk_last(blk_last), .blk_err(blk_err),
      .st(st), .st_valid(st_valid)
   );

   csrw_bit_rewrite #(.IDX_W(IDX_W)) rw_i (
      .clk(clk), .rst_n(rst_n), .rw_en(rw_en), .sub_valid(in_valid),
      .sub_chan(in_chan), .sub_bos(in_bos), .sub_data(in_sub),
      .cur_sync(cur_sync), .cur_idx(cur_idx), .out_valid(out_valid),
      .out_chan(out_chan), .out_bos(out_bos), .out_data(out_sub)
   );

   assign st_pro      = st.pro;
   assign st_nonaudio = st.nonaudio;
   assign st_copy_ok  = st.copy_ok;
   assign st_emph     = st.emph;
   assign st_mode     = st.mode;
   assign st_category = st.category;
   assign st_rate     = st.rate;
   assign st_is_dat   = st.is_dat;
   assign st_is_datp  = st.is_datp;

endmodule

// File: tb/csrw_rewriter_tb_top.sv
module csrw_rewriter_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int BLK        = 192;

   logic clk = 1'b0, rst_n = 1'b0, rw_en = 1'b0;
   logic in_valid = 1'b0, in_chan = 1'b0, in_bos = 1'b0;
   logic [31:0] in_sub = '0;
   logic out_valid, out_chan, out_bos;
   logic [31:0] out_sub;
   logic st_valid, st_pro, st_nonaudio, st_copy_ok, st_is_dat, st_is_datp;
   logic [1:0] st_emph, st_mode, st_rate;
   logic [7:0] st_category;

   csrw_rewriter dut_i (
      .clk(clk), .rst_n(rst_n), .rw_en(rw_en), .in_valid(in_valid),
      .in_chan(in_chan), .in_bos(in_bos), .in_sub(in_sub),
      .out_valid(out_valid), .out_chan(out_chan), .out_bos(out_bos),
      .out_sub(out_sub), .st_valid(st_valid), .st_pro(st_pro),
      .st_nonaudio(st_nonaudio), .st_copy_ok(st_copy_ok), .st_emph(st_emph),
      .st_mode(st_mode), .st_category(st_category), .st_rate(st_rate),
      .st_is_dat(st_is_dat), .st_is_datp(st_is_datp)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   int checks = 0, errors = 0, aud_ctr = 0;
   bit pend = 0, pend_chan, pend_bos;
   logic [31:0] pend_sub;
   string pend_req;
   bit b_sync = 0;
   int b_cnt = 0;

   // Headers: status bits 0..31 of a block
   // H_PRO: professional, copy prohibited, emphasis, mode 0, tape category, 48 kHz
   localparam logic [31:0] H_PRO  = (32'h1 << 0) | (32'h1 << 3) | (32'h3 << 8) | (32'h1 << 25);
   // H_DATP: consumer, copy permitted, mode 0, tape copy-permitted category, 32 kHz
   localparam logic [31:0] H_DATP = (32'h1 << 2) | (32'h83 << 8) | (32'h3 << 24);
   // H_M1: mode 01 with nonzero category and rate bits
   localparam logic [31:0] H_M1   = (32'h1 << 1) | (32'h1 << 6) | (32'h3 << 8) | (32'h3 << 24);

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] mk(input logic c, input bit badp);
      logic [31:0] s;
      logic [23:0] aud;
      aud = 24'(aud_ctr * 24'h9E37 + 24'h1234);
      s = {1'b0, c, aud[3], aud[7], aud, 4'b0000};
      s[31] = (^s[30:4]) ^ badp;
      return s;
   endfunction

   task automatic check_pending();
      if (pend) begin
         chk("R1 valid", {63'd0, out_valid}, 64'd1);
         chk("R1 chan/bos", {62'd0, out_chan, out_bos}, {62'd0, pend_chan, pend_bos});
         chk(pend_req, {32'd0, out_sub}, {32'd0, pend_sub});
      end else begin
         chk("R1 idle", {63'd0, out_valid}, 64'd0);
      end
   endtask

   task automatic drive_sub(input logic chan, input logic bos, input logic [31:0] sub);
      logic [31:0] exp;
      bit synced;
      int idx;
      string req;
      @(negedge clk);
      check_pending();
      in_valid = 1'b1; in_chan = chan; in_bos = bos; in_sub = sub;
      exp = sub;
      req = chan ? "R2 ch2 passthrough" : (rw_en ? "R4 rewrite" : "R3 rewrite off");
      if (!chan) begin
         if (bos) begin synced = 1; idx = 0; end
         else if (b_sync && b_cnt < BLK) begin synced = 1; idx = b_cnt; end
         else begin synced = 0; idx = -1; end
         if (!synced) req = "R6 untracked passthrough";
         if (rw_en && synced && (idx == 0 || idx == 2 || idx == 3)) begin
            if (exp[30] != (idx == 2)) begin
               exp[30] = (idx == 2);
               exp[31] = ^exp[30:4];
               req = "R5 parity after rewrite";
            end else begin
               req = "R5 parity untouched";
            end
         end
         if (bos) begin b_sync = 1; b_cnt = 1; end
         else if (b_sync) begin
            if (b_cnt == BLK) b_sync = 0;
            else b_cnt++;
         end
      end
      pend = 1; pend_chan = chan; pend_bos = bos; pend_sub = exp; pend_req = req;
   endtask

   task automatic flush();
      @(negedge clk);
      check_pending();
      in_valid = 1'b0; in_bos = 1'b0; in_chan = 1'b0; in_sub = '0;
      pend = 0;
   endtask

   task automatic send_range(input logic [31:0] hdr, input int first, input int last,
                             input bit bos_first, input int badp_idx);
      for (int k = first; k <= last; k++) begin
         logic c;
         c = (k < 32) ? hdr[k] : 1'b0;
         aud_ctr++;
         drive_sub(1'b0, bos_first && (k == first), mk(c, k == badp_idx));
         aud_ctr++;
         drive_sub(1'b1, 1'b0, mk(c, 0));
         if (k % 17 == 5) flush();
      end
   endtask

   task automatic check_status(input string tag, input logic [31:0] h, input bit vexp);
      logic m0;
      m0 = (h[7:6] == 2'b00);
      chk({"R10 ", tag, " st_valid"}, {63'd0, st_valid}, {63'd0, vexp});
      chk({"R7 ", tag, " flags"}, {61'd0, st_pro, st_nonaudio, st_copy_ok}, {61'd0, h[0], h[1], h[2]});
      chk({"R7 ", tag, " emph/mode"}, {60'd0, st_emph, st_mode}, {60'd0, h[4], h[3], h[7], h[6]});
      chk({"R8 ", tag, " category"}, {56'd0, st_category}, {56'd0, m0 ? h[15:8] : 8'h00});
      chk({"R8 ", tag, " rate"}, {62'd0, st_rate}, {62'd0, m0 ? {h[25], h[24]} : 2'b00});
      chk({"R9 ", tag, " dat/datp"}, {62'd0, st_is_dat, st_is_datp},
          {62'd0, m0 && h[15:8] == 8'h03, m0 && h[15:8] == 8'h83});
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      chk("R11 out_valid in reset", {63'd0, out_valid}, 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R11 out_valid", {63'd0, out_valid}, 64'd0);
      check_status("reset", 32'h0, 0);
   endtask

   task automatic t_untracked();
      rw_en = 1'b1;
      send_range(H_PRO, 0, 5, 0, -1);
      flush();
      chk("R6 no status before block", {63'd0, st_valid}, 64'd0);
   endtask

   task automatic t_pass_block();
      rw_en = 1'b0;
      send_range(H_PRO, 0, BLK-1, 1, -1);
      flush();
      check_status("pro block", H_PRO, 1);
   endtask

   task automatic t_rewrite_block();
      rw_en = 1'b1;
      send_range(H_PRO, 0, BLK-1, 1, -1);
      flush();
      check_status("rewritten source", H_PRO, 1);
   endtask

   task automatic t_datp_block();
      rw_en = 1'b1;
      send_range(H_DATP, 0, BLK-1, 1, 0);
      flush();
      check_status("datp", H_DATP, 1);
   endtask

   task automatic t_mode1_block();
      rw_en = 1'b1;
      send_range(H_M1, 0, BLK-1, 1, 1);
      flush();
      check_status("mode1", H_M1, 1);
   endtask

   task automatic t_early();
      send_range(H_PRO, 0, 49, 1, -1);
      flush();
      chk("R10 still valid mid block", {63'd0, st_valid}, 64'd1);
      send_range(H_PRO, 0, 0, 1, -1);
      flush();
      chk("R10 early start clears", {63'd0, st_valid}, 64'd0);
      send_range(H_PRO, 1, BLK-1, 0, -1);
      flush();
      check_status("after early", H_PRO, 1);
   endtask

   task automatic t_late();
      send_range(H_PRO, BLK, BLK, 0, -1);
      flush();
      chk("R10 late frame clears", {63'd0, st_valid}, 64'd0);
      send_range(H_PRO, 0, 4, 0, -1);
      flush();
      send_range(H_DATP, 0, BLK-1, 1, -1);
      flush();
      check_status("resync", H_DATP, 1);
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      t_reset();
      t_untracked();
      t_pass_block();
      t_rewrite_block();
      t_datp_block();
      t_mode1_block();
      t_early();
      t_late();
      repeat (2) @(negedge clk);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule